// File: doc/BRIEF.md
# Compact 16-bit shift and add executor

This block executes a small family of compressed 16-bit instructions on eight 32-bit general registers and a four-bit condition flag set (N, Z, C, V). It handles three instruction groups: a shift of one register by a five-bit immediate amount, an add or subtract with a register or three-bit immediate operand, and a group that works on one register and an 8-bit immediate (move, compare, add and subtract). Each legal instruction updates the flags. Every group except compare also writes a destination register.

A producer presents one instruction per cycle with a valid strobe. A legal instruction commits its register and flag results at the next rising clock edge. An encoding outside the three groups raises `illegal` during the cycle it is presented and leaves all state as it was. A combinational debug port returns any register and the current flags, so a test environment can observe the architectural state without extra cycles.

Top module: `lo16_exec`

## Requirements
- R1: With `in_valid` high, `illegal` is high in that same cycle exactly when the encoding is outside all three groups. A legal group is bits 15:11 = 00011, or bits 15:13 = 000, or bits 15:13 = 001. An illegal instruction changes no register and no flag.
- R2: The shift group is bits 15:13 = 000 with bits 12:11 not 11. Bits 12:11 give the kind (00 logical left, 01 logical right, 10 arithmetic right), bits 10:6 the amount, bits 5:3 the source and bits 2:0 the destination.
- R3: A shift amount field of 0 has special meaning. For a left shift it leaves both the value and C unchanged. For the two right shifts it means a shift by 32: C takes bit 31, and the result is 0 (logical) or 32 copies of bit 31 (arithmetic).
- R4: A shift sets C to the last bit shifted out, N to result bit 31 and Z when the result is zero. It leaves V unchanged.
- R5: The add/subtract group is bits 15:11 = 00011. Bit 10 = 1 selects a 3-bit immediate in bits 8:6, and bit 10 = 0 selects the register named by bits 8:6. Bit 9 = 1 subtracts that operand from the register in bits 5:3. The result goes to the register in bits 2:0.
- R6: The immediate group is bits 15:13 = 001, with bits 10:8 naming one register that is both source and destination, and bits 7:0 an unsigned immediate. Bits 12:11 select the operation: 00 loads the zero-extended immediate, 10 adds it and 11 subtracts it. A load sets N and Z and keeps C and V.
- R7: Immediate-group operation 01 (compare) computes register minus immediate and updates all four flags, but writes no register.
- R8: For add, C is the carry out. For subtract and compare, C is 1 when no borrow occurs. V is two's-complement overflow, N is result bit 31, and Z is 1 for a zero 32-bit result.
- R9: Results appear after the rising edge that samples a legal instruction, and back-to-back instructions use the prior results. With `in_valid` low, nothing changes.
- R10: Reset is synchronous and active low. It clears all eight registers and all four flags, and it takes priority over a valid instruction in the same cycle.
- R11: `dbg_data` combinationally shows the register selected by `dbg_sel`. `dbg_flags` shows the flags as {N, Z, C, V}, with N in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 16 | Instruction word |
| illegal | output | 1 | Valid instruction outside the supported groups |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | DATA_W (32) | Contents of the selected register |
| dbg_flags | output | 4 | Flags {N, Z, C, V} |

## Verification
The bench builds the block with its default 32-bit data width, which gives eight registers from the three-bit fields. At this width the shift-by-32 meaning of a zero right-shift amount, the carry out of bit 31 and the signed overflow boundaries between 0x7FFFFFFF and 0x80000000 are all within reach. Directed cases cover those boundaries along with compare, illegal encodings and reset priority. A long stream of random encodings then mixes all groups with illegal words, and a bench model of the registers and flags checks every result.

// File: rtl/lo16_pkg.sv
// Package: shared field widths, flag bit positions and the decoded
// instruction record used by the decoder and the executor top.
// Assumes the register fields in every encoding are three bits wide.
package lo16_pkg;

    localparam int RF_W = 3;   // register index field width
    localparam int FL_N = 3;   // flag bit positions in the flag vector
    localparam int FL_Z = 2;
    localparam int FL_C = 1;
    localparam int FL_V = 0;

    typedef enum logic [1:0] {
        GRP_NONE   = 2'd0,
        GRP_SHIFT  = 2'd1,
        GRP_ADDSUB = 2'd2,
        GRP_IMM8   = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_RSV = 2'b11
    } shop_e;

    typedef struct packed {
        grp_e            grp;
        shop_e           sh_op;
        logic [4:0]      amt;
        logic            is_sub;
        logic            is_mov;
        logic            wr_en;
        logic            b_imm;
        logic [RF_W-1:0] rd;
        logic [RF_W-1:0] ra;
        logic [RF_W-1:0] rb;
        logic [7:0]      imm;
    } dec_t;

endpackage

// File: rtl/lo16_decode.sv
// Decoder: splits a 16-bit word into group, operation and operand fields.
// Assumes the add/subtract pattern is tested before the shift pattern,
// because both share bits 15:13 = 000.
module lo16_decode
    import lo16_pkg::*;
(
    input  logic [15:0] instr,
    output dec_t        dec
);

    // Pattern match on the opcode bits and field extraction.
    always_comb begin
        dec = '0;
        if (instr[15:11] == 5'b00011) begin
            dec.grp    = GRP_ADDSUB;
            dec.b_imm  = instr[10];
            dec.is_sub = instr[9];
            dec.rb     = instr[8:6];
            dec.imm    = {5'b0, instr[8:6]};
            dec.ra     = instr[5:3];
            dec.rd     = instr[2:0];
            dec.wr_en  = 1'b1;
        end else if (instr[15:13] == 3'b000) begin
            dec.grp    = GRP_SHIFT;
            dec.sh_op  = shop_e'(instr[12:11]);
            dec.amt    = instr[10:6];
            dec.ra     = instr[5:3];
            dec.rd     = instr[2:0];
            dec.wr_en  = 1'b1;
        end else if (instr[15:13] == 3'b001) begin
            dec.grp    = GRP_IMM8;
            dec.rd     = instr[10:8];
            dec.ra     = instr[10:8];
            dec.imm    = instr[7:0];
            dec.b_imm  = 1'b1;
            dec.is_mov = (instr[12:11] == 2'b00);
            dec.is_sub = instr[11];
            dec.wr_en  = (instr[12:11] != 2'b01);
        end
    end

endmodule

// File: rtl/lo16_shift.sv
// Immediate shifter: logical left, logical right and arithmetic right.
// Assumes an amount of zero means "no shift" for left and a full-width
// shift for both right shifts; carry is the last bit shifted out.
module lo16_shift
    import lo16_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  shop_e             op,
    input  logic [4:0]        amt,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);

    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [SH_W-1:0]          amt_eff;
    logic [DATA_W:0]          lsl_ext;
    logic [DATA_W:0]          lsr_ext;
    logic signed [DATA_W:0]   asr_ext;

    // Widen the amount and form the three extended shifts, carry included.
    always_comb begin
        amt_eff = (amt == 5'd0) ? SH_W'(DATA_W) : SH_W'(amt);
        lsl_ext = {1'b0, a} << amt_eff;
        lsr_ext = {a, 1'b0} >> amt_eff;
        asr_ext = $signed({a, 1'b0}) >>> amt_eff;
    end

    // Select result and carry for the requested kind.
    always_comb begin
        unique case (op)
            SH_LSL: begin
                if (amt == 5'd0) begin
                    res   = a;
                    c_out = c_in;
                end else begin
                    res   = lsl_ext[DATA_W-1:0];
                    c_out = lsl_ext[DATA_W];
                end
            end
            SH_LSR: begin
                res   = lsr_ext[DATA_W:1];
                c_out = lsr_ext[0];
            end
            SH_ASR: begin
                res   = asr_ext[DATA_W:1];
                c_out = asr_ext[0];
            end
            default: begin
                res   = a;
                c_out = c_in;
            end
        endcase
    end

endmodule

// File: rtl/lo16_addsub.sv
// Adder/subtractor with carry (not-borrow on subtract) and signed overflow.
// Assumes two's-complement operands of DATA_W bits.
module lo16_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              v_out
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;

    // Subtract as a + ~b + 1; overflow when like-signed inputs change sign.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        res   = sum[DATA_W-1:0];
        c_out = sum[DATA_W];
        v_out = (a[DATA_W-1] == b_eff[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
    end

endmodule

// File: rtl/lo16_exec.sv
// Executor top: register file, flag register, operand selection and commit.
// Assumes one instruction per valid cycle, results committed at the next
// rising edge, synchronous active-low reset with priority over commit.
module lo16_exec
    import lo16_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       in_instr,
    output logic              illegal,
    input  logic [RF_W-1:0]   dbg_sel,
    output logic [DATA_W-1:0] dbg_data,
    output logic [3:0]        dbg_flags
);

    localparam int NUM_REGS = 1 << RF_W;

    logic [DATA_W-1:0]          rf [NUM_REGS];
    logic [3:0]                 flag_q;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    dec_t              dec;
    logic [DATA_W-1:0] op_a, op_b, imm_ext;
    logic [DATA_W-1:0] sh_res, as_res, result;
    logic              sh_c, as_c, as_v;
    logic [3:0]        flag_d;
    logic              legal, commit;

    lo16_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    // Operand fetch from the register file or the immediate field.
    always_comb begin
        imm_ext = {{(DATA_W-8){1'b0}}, dec.imm};
        op_a    = rf[dec.ra];
        op_b    = dec.b_imm ? imm_ext : rf[dec.rb];
    end

    lo16_shift #(.DATA_W(DATA_W)) u_shift (
        .a     (op_a),
        .op    (dec.sh_op),
        .amt   (dec.amt),
        .c_in  (flag_q[FL_C]),
        .res   (sh_res),
        .c_out (sh_c)
    );

    lo16_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a     (op_a),
        .b     (op_b),
        .sub   (dec.is_sub),
        .res   (as_res),
        .c_out (as_c),
        .v_out (as_v)
    );

    // Result and next-flag selection per group.
    always_comb begin
        result = as_res;
        flag_d = flag_q;
        if (dec.grp == GRP_SHIFT) begin
            result       = sh_res;
            flag_d[FL_C] = sh_c;
        end else if (dec.is_mov) begin
            result = imm_ext;
        end else begin
            flag_d[FL_C] = as_c;
            flag_d[FL_V] = as_v;
        end
        flag_d[FL_N] = result[DATA_W-1];
        flag_d[FL_Z] = (result == '0);
    end

    // Legality and commit strobe.
    always_comb begin
        legal   = (dec.grp != GRP_NONE);
        commit  = in_valid && legal;
        illegal = in_valid && !legal;
    end

    // State update: reset clears everything, otherwise commit results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                rf[i] <= '0;
            end
        end else if (commit) begin
            flag_q <= flag_d;
            if (dec.wr_en) begin
                rf[dec.rd] <= result;
            end
        end
    end

    // Flattened register view for the checker.
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
            assign regs_flat[g*DATA_W +: DATA_W] = rf[g];
        end
    endgenerate

    // Debug read port.
    always_comb begin
        dbg_data  = rf[dbg_sel];
        dbg_flags = flag_q;
    end

endmodule

// File: rtl/lo16_exec_chk.sv
// Checker: temporal properties on the executor's state and ports.
// Assumes it is bound into lo16_exec and sees its flattened register view.
module lo16_exec_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [15:0]                  in_instr,
    input logic                         illegal,
    input logic [NUM_REGS*DATA_W-1:0]   regs_flat,
    input logic [3:0]                   flag_q
);

    // R10: a reset edge leaves all registers and flags cleared.
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == '0) && (flag_q == 4'd0));

    // R1: illegal is only raised for a presented instruction.
    a_r1_illegal_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> in_valid);

    // R1: an illegal instruction changes no state.
    a_r1_illegal_no_state: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(regs_flat) && $stable(flag_q));

    // R9: an idle cycle changes no state.
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(regs_flat) && $stable(flag_q));

    // R7: compare writes no register.
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[15:11] == 5'b00101) |=> $stable(regs_flat));

    // R4: shifts keep V.
    a_r4_shift_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[15:13] == 3'b000 && in_instr[12:11] != 2'b11)
        |=> $stable(flag_q[0]));

    // R6: loading a zero immediate sets Z and clears N.
    a_r6_mov_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[15:11] == 5'b00100 && in_instr[7:0] == 8'd0)
        |=> flag_q[2] && !flag_q[3]);

endmodule

bind lo16_exec lo16_exec_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_instr  (in_instr),
    .illegal   (illegal),
    .regs_flat (regs_flat),
    .flag_q    (flag_q)
);

// File: tb/lo16_exec_tb.sv
// Scoreboard bench: the driver models each instruction and queues the
// expected register and flags; the monitor reads them back after commit.
`timescale 1ns/1ps
module lo16_exec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = 16'h0;
    logic        illegal;
    logic [2:0]  dbg_sel = 3'd0;
    logic [31:0] dbg_data;
    logic [3:0]  dbg_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // expected-state model
    logic [31:0] m_reg [8];
    logic        m_n, m_z, m_c, m_v;

    // scoreboard queues
    int          q_dst [$];
    logic [31:0] q_val [$];
    logic [3:0]  q_flg [$];
    string       q_tag [$];

    always #2.5 clk = ~clk;

    lo16_exec u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_instr  (in_instr),
        .illegal   (illegal),
        .dbg_sel   (dbg_sel),
        .dbg_data  (dbg_data),
        .dbg_flags (dbg_flags)
    );

    function automatic logic [15:0] enc_sh(input logic [1:0] op, input logic [4:0] amt,
                                           input logic [2:0] rs, input logic [2:0] rd);
        return {3'b000, op, amt, rs, rd};
    endfunction

    function automatic logic [15:0] enc_as(input logic im, input logic sb, input logic [2:0] n,
                                           input logic [2:0] rs, input logic [2:0] rd);
        return {5'b00011, im, sb, n, rs, rd};
    endfunction

    function automatic logic [15:0] enc_i8(input logic [1:0] op, input logic [2:0] rd,
                                           input logic [7:0] imm);
        return {3'b001, op, rd, imm};
    endfunction

    // Model: add or subtract with flag results, written from the requirements.
    task automatic m_arith(input logic [31:0] a, input logic [31:0] b, input bit sub,
                           output logic [31:0] r);
        logic [32:0] wide;
        if (!sub) begin
            wide = {1'b0, a} + {1'b0, b};
            r    = wide[31:0];
            m_c  = wide[32];
            m_v  = (a[31] == b[31]) && (r[31] != a[31]);
        end else begin
            r    = a - b;
            m_c  = (a >= b);
            m_v  = (a[31] != b[31]) && (r[31] != a[31]);
        end
    endtask

    // Model: apply one instruction; returns the register to inspect.
    task automatic m_apply(input logic [15:0] ins, output int dst, output bit legal);
        logic [31:0] r;
        bit          wr;
        legal = 1'b1;
        wr    = 1'b1;
        dst   = int'(ins[2:0]);
        r     = 32'h0;
        if (ins[15:11] == 5'b00011) begin
            m_arith(m_reg[ins[5:3]], ins[10] ? {29'd0, ins[8:6]} : m_reg[ins[8:6]], ins[9], r);
        end else if (ins[15:13] == 3'b000) begin
            int n;
            r = m_reg[ins[5:3]];
            n = int'(ins[10:6]);
            if (n == 0 && ins[12:11] != 2'b00) n = 32;
            for (int k = 0; k < n; k++) begin
                if (ins[12:11] == 2'b00) begin
                    m_c = r[31]; r = {r[30:0], 1'b0};
                end else if (ins[12:11] == 2'b01) begin
                    m_c = r[0];  r = {1'b0, r[31:1]};
                end else begin
                    m_c = r[0];  r = {r[31], r[31:1]};
                end
            end
        end else if (ins[15:13] == 3'b001) begin
            dst = int'(ins[10:8]);
            case (ins[12:11])
                2'b00: r = {24'd0, ins[7:0]};
                2'b01: begin m_arith(m_reg[ins[10:8]], {24'd0, ins[7:0]}, 1'b1, r); wr = 1'b0; end
                2'b10: m_arith(m_reg[ins[10:8]], {24'd0, ins[7:0]}, 1'b0, r);
                default: m_arith(m_reg[ins[10:8]], {24'd0, ins[7:0]}, 1'b1, r);
            endcase
        end else begin
            legal = 1'b0;
        end
        if (legal) begin
            m_n = r[31];
            m_z = (r == 32'h0);
            if (wr) m_reg[dst] = r;
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: present one instruction, check illegal, queue expected state.
    task automatic issue(input logic [15:0] ins, input bit v, input string tag);
        int d;
        bit lg;
        @(negedge clk);
        in_valid = v;
        in_instr = ins;
        d  = int'(ins[2:0]);
        lg = 1'b1;
        if (v) m_apply(ins, d, lg);
        #1;
        check(illegal == (v && !lg), tag, {31'd0, illegal}, {31'd0, v && !lg});
        q_dst.push_back(d);
        q_val.push_back(m_reg[d]);
        q_flg.push_back({m_n, m_z, m_c, m_v});
        q_tag.push_back(tag);
    endtask

    // Reset sequence with a competing valid instruction; then read all state.
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_instr = enc_i8(2'b00, 3'd3, 8'h09);
        @(negedge clk);
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < 8; i++) m_reg[i] = 32'h0;
        {m_n, m_z, m_c, m_v} = 4'h0;
        for (int i = 0; i < 8; i++) begin
            q_dst.push_back(i);
            q_val.push_back(32'h0);
            q_flg.push_back(4'h0);
            q_tag.push_back(tag);
        end
        wait (q_dst.size() == 0);
    endtask

    // Monitor: after each rising edge, pop one expected item and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_dst.size() > 0) begin
                int          d;
                logic [31:0] ev;
                logic [3:0]  ef;
                string       t;
                d  = q_dst.pop_front();
                ev = q_val.pop_front();
                ef = q_flg.pop_front();
                t  = q_tag.pop_front();
                dbg_sel = d[2:0];
                #0.5;
                check(dbg_data === ev, t, dbg_data, ev);
                check(dbg_flags === ef, t, {28'd0, dbg_flags}, {28'd0, ef});
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Stimulus
    initial begin
        logic [15:0] w;
        do_reset("R10 R11");

        issue(enc_i8(2'b00, 3'd0, 8'h80), 1, "R6");
        issue(enc_i8(2'b00, 3'd1, 8'h00), 1, "R6");
        issue(enc_i8(2'b00, 3'd2, 8'hFF), 1, "R6");
        issue(enc_sh(2'b00, 5'd24, 3'd2, 3'd3), 1, "R2");
        issue(enc_sh(2'b00, 5'd1, 3'd3, 3'd4), 1, "R4");
        issue(enc_sh(2'b00, 5'd0, 3'd4, 3'd5), 1, "R3");
        issue(enc_sh(2'b01, 5'd0, 3'd3, 3'd6), 1, "R3");
        issue(enc_sh(2'b10, 5'd4, 3'd3, 3'd7), 1, "R2");
        issue(enc_sh(2'b10, 5'd0, 3'd3, 3'd6), 1, "R3");
        issue(enc_sh(2'b01, 5'd31, 3'd3, 3'd5), 1, "R2");
        issue(enc_sh(2'b01, 5'd1, 3'd6, 3'd1), 1, "R4");
        issue(enc_as(1, 0, 3'd1, 3'd1, 3'd1), 1, "R8");
        issue(enc_sh(2'b01, 5'd4, 3'd1, 3'd2), 1, "R4");
        issue(enc_as(1, 1, 3'd1, 3'd1, 3'd4), 1, "R8");
        issue(enc_i8(2'b00, 3'd2, 8'hFF), 1, "R9");
        issue(enc_as(0, 0, 3'd2, 3'd0, 3'd0), 1, "R5");
        issue(enc_as(0, 1, 3'd0, 3'd0, 3'd5), 1, "R8");
        issue(enc_as(0, 1, 3'd0, 3'd2, 3'd5), 1, "R8");
        issue(enc_as(1, 0, 3'd1, 3'd6, 3'd6), 1, "R8");
        issue(enc_i8(2'b00, 3'd7, 8'h41), 1, "R6");
        issue(enc_i8(2'b01, 3'd2, 8'hFF), 1, "R7");
        issue(enc_i8(2'b01, 3'd0, 8'hFF), 1, "R7");
        issue(enc_i8(2'b10, 3'd2, 8'h01), 1, "R6");
        issue(enc_i8(2'b11, 3'd2, 8'h80), 1, "R6");
        issue(enc_i8(2'b00, 3'd3, 8'h05), 0, "R9");
        issue(16'h4000, 1, "R1");
        issue(16'hE7FF, 1, "R1");
        issue(16'hFFFF, 1, "R1");

        for (int i = 0; i < 300; i++) begin
            w = 16'($urandom);
            if ((i % 4) != 3) w[15] = 1'b0;
            if ((i % 4) == 0) w[14] = 1'b0;
            issue(w, (i % 9) != 8, "R2 R5 R6 R7 R8 R1");
        end

        do_reset("R10");
        wait (q_dst.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule